// File: doc/BRIEF.md
# Serial Divider-Setting Reconfiguration Port

This block holds the frequency and duty settings for a bank of clock divider counters and lets them be rewritten at run time through a one-bit serial port. A new configuration image is streamed in, one bit per scan clock, into a shadow shift register. The image held there before streams out of a serial output at the same rate, least significant bit first. This lets the caller read back the old settings while it writes the new ones.

The divider counters never see the shadow register. They see a separate active bank. The active bank takes the whole shadow image in one scan clock edge when an update strobe is raised. A done flag drops at that edge and comes back two scan clocks later. The serial input follows valid/ready rules. A bit is taken only on an edge where the valid input (the scan clock enable) and the ready output are both high. Ready goes low while the strobe is high and during the two busy cycles, so the sender must hold its bit until ready returns. The port reaches only the counts, the bypass bit and the odd-duty bit of each counter. Phase settings are not part of the chain.

Top module: `scan_reconfig`

## Requirements
- R1: Serial bits are accepted least significant bit first. After exactly NUM_CNT*18 accepted bits, the first accepted bit sits in shadow bit 0 and the last accepted bit sits in the top bit.
- R2: The shadow image and `sdata_o` change only on an edge where `svld_i` and `srdy_o` are both high. On any other edge they hold.
- R3: `sdata_o` always shows shadow bit 0. While a new image is shifted in, the previous image comes out in order from bit 0 upward.
- R4: `srdy_o` is low whenever `upd_i` is high and during the two busy cycles after an update starts. A bit offered then is not taken.
- R5: The active bank loads the whole shadow image on the first rising edge of `clk` where `upd_i` is high, the sequencer is idle and `upd_i` was low on the edge before. On every other edge the active bank holds. A strobe held high starts only one update.
- R6: `done_o` falls on the edge that starts an update, stays low on the next edge, and rises on the second edge after the start. It then stays high until the next update starts.
- R7: An active-low asynchronous reset sets every counter slot in both shadow and active registers to the default value 18'h10000 (bypass set, all counts zero) and clears `done_o`.
- R8: Counter k occupies image bits [18k+17:18k]. Within the slot, bits [7:0] are the high count, [15:8] the low count, bit 16 the bypass bit and bit 17 the odd-duty select.
- R9: `div_ratio_o[9k+8:9k]` gives 1 when counter k's active bypass bit is set. Otherwise it gives the 9-bit sum of the active high and low counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial configuration bit in |
| svld_i | input | 1 | Scan clock enable; the offered bit is valid |
| srdy_o | output | 1 | Port can accept a serial bit this edge |
| sdata_o | output | 1 | Serial output of the previous image, shadow bit 0 |
| upd_i | input | 1 | Update strobe: copy the shadow image into the active bank |
| done_o | output | 1 | Last update complete |
| act_cfg_o | output | NUM_CNT*18 | Active settings of all counters |
| div_ratio_o | output | NUM_CNT*9 | Effective division of each counter |

## Verification
The bench builds the port with NUM_CNT=2, which gives a 36-bit chain. A full image therefore shifts through in 36 clocks, so several images can be loaded one after another. Each load streams the previous image back out completely, and the bench compares that readback bit by bit. With two counters, a single pair of images covers a split duty cycle (4 and 6), an even one (5 and 5), the bypass override and the odd-duty bit. The small size also keeps the update, held-strobe and mid-run reset cases short enough to check cycle by cycle.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int CNT_BITS   = 18;
  localparam int HI_LSB     = 0;
  localparam int LO_LSB     = 8;
  localparam int CNT_W      = 8;
  localparam int BYP_BIT    = 16;
  localparam int ODD_BIT    = 17;
  localparam int RATIO_W    = CNT_W + 1;
  localparam logic [CNT_BITS-1:0] SLOT_DEFAULT = 18'h10000;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BUSY1 = 2'd1,
    SEQ_BUSY2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/scr_shift_reg.sv
module scr_shift_reg #(
  parameter int L = 36,
  parameter logic [L-1:0] RST_IMG = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic         sout,
  output logic [L-1:0] image_o
);
  logic [L-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= RST_IMG;
    else if (shift_en) sr_q <= {sin, sr_q[L-1:1]};
  end

  assign sout    = sr_q[0];
  assign image_o = sr_q;
endmodule

// File: rtl/scr_upd_seq.sv
module scr_upd_seq
  import scr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  output logic start_o,
  output logic idle_o,
  output logic done_o
);
  seq_state_e state_q;
  logic       upd_q;
  logic       done_q;

  assign idle_o  = (state_q == SEQ_IDLE);
  assign start_o = idle_o && upd_i && !upd_q;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      upd_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      upd_q <= upd_i;
      unique case (state_q)
        SEQ_IDLE: if (start_o) begin
          state_q <= SEQ_BUSY1;
          done_q  <= 1'b0;
        end
        SEQ_BUSY1: state_q <= SEQ_BUSY2;
        SEQ_BUSY2: begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scr_active_bank.sv
module scr_active_bank
  import scr_pkg::*;
#(
  parameter int NUM_CNT = 10,
  localparam int L = NUM_CNT * CNT_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [L-1:0]               img_i,
  output logic [L-1:0]               act_o,
  output logic [NUM_CNT*RATIO_W-1:0] ratio_o
);
  logic [L-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= {NUM_CNT{SLOT_DEFAULT}};
    else if (load) act_q <= img_i;
  end

  assign act_o = act_q;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    logic [CNT_BITS-1:0] slot;
    logic [CNT_W-1:0]    hi_cnt;
    logic [CNT_W-1:0]    lo_cnt;
    assign slot   = act_q[k*CNT_BITS +: CNT_BITS];
    assign hi_cnt = slot[HI_LSB +: CNT_W];
    assign lo_cnt = slot[LO_LSB +: CNT_W];
    assign ratio_o[k*RATIO_W +: RATIO_W] = slot[BYP_BIT] ? RATIO_W'(1)
                                         : ({1'b0, hi_cnt} + {1'b0, lo_cnt});
  end
endmodule

// File: rtl/scan_reconfig.sv
module scan_reconfig
  import scr_pkg::*;
#(
  parameter int NUM_CNT = 10,
  localparam int L = NUM_CNT * CNT_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sdata_i,
  input  logic                       svld_i,
  output logic                       srdy_o,
  output logic                       sdata_o,
  input  logic                       upd_i,
  output logic                       done_o,
  output logic [L-1:0]               act_cfg_o,
  output logic [NUM_CNT*RATIO_W-1:0] div_ratio_o
);
  logic         upd_start;
  logic         seq_idle;
  logic [L-1:0] shadow_img;

  assign srdy_o = seq_idle && !upd_i;

  scr_upd_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd_i),
    .start_o(upd_start),
    .idle_o (seq_idle),
    .done_o (done_o)
  );

  scr_shift_reg #(.L(L), .RST_IMG({NUM_CNT{SLOT_DEFAULT}})) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(svld_i && srdy_o),
    .sin     (sdata_i),
    .sout    (sdata_o),
    .image_o (shadow_img)
  );

  scr_active_bank #(.NUM_CNT(NUM_CNT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (upd_start),
    .img_i  (shadow_img),
    .act_o  (act_cfg_o),
    .ratio_o(div_ratio_o)
  );
endmodule

// File: rtl/scan_reconfig_chk.sv
module scan_reconfig_chk #(
  parameter int L = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         svld_i,
  input logic         srdy_o,
  input logic         sdata_o,
  input logic         upd_i,
  input logic         done_o,
  input logic [L-1:0] act_cfg_o
);
  logic upd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_seen <= 1'b0;
    else upd_seen <= upd_i;
  end

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(svld_i && srdy_o) |=> $stable(sdata_o));

  // R4
  rdy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |-> !srdy_o);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(act_cfg_o));

  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !upd_seen && done_o) |=> !done_o);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !$past(done_o, 2));
endmodule

bind scan_reconfig scan_reconfig_chk #(.L(L)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .svld_i   (svld_i),
  .srdy_o   (srdy_o),
  .sdata_o  (sdata_o),
  .upd_i    (upd_i),
  .done_o   (done_o),
  .act_cfg_o(act_cfg_o)
);

// File: tb/test_scan_reconfig.sv
`timescale 1ns/1ps
module test_scan_reconfig;
  localparam int NC = 2;
  localparam int L  = NC * 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata_i = 1'b0, svld_i = 1'b0, upd_i = 1'b0;
  logic srdy_o, sdata_o, done_o;
  logic [L-1:0]    act_cfg_o;
  logic [NC*9-1:0] div_ratio_o;

  int checks = 0, fails = 0;
  logic [L-1:0] model;
  logic exp_q[$];
  logic [L-1:0] img_a, img_b, dflt;

  always #10 clk = ~clk;

  scan_reconfig #(.NUM_CNT(NC)) i_scan_reconfig (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata_i), .svld_i(svld_i),
    .srdy_o(srdy_o), .sdata_o(sdata_o), .upd_i(upd_i), .done_o(done_o),
    .act_cfg_o(act_cfg_o), .div_ratio_o(div_ratio_o));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] slot(input int hi, input int lo, input bit byp, input bit odd);
    return {odd, byp, 8'(lo), 8'(hi)};
  endfunction

  function automatic logic [8:0] ratio_of(input logic [17:0] s);
    return s[16] ? 9'd1 : ({1'b0, s[7:0]} + {1'b0, s[15:8]});
  endfunction

  // monitor: pops expected readback bits on accepted shifts (R3)
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (svld_i && srdy_o) begin
        if (exp_q.size() == 0) check(1'b0, "R3 queue empty", 64'(sdata_o), 0);
        else begin
          logic e;
          e = exp_q.pop_front();
          check(sdata_o == e, "R3 readback bit", 64'(sdata_o), 64'(e));
        end
      end
    end
  end

  task automatic shift_in(input logic [L-1:0] img);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      sdata_i = img[i];
      svld_i  = 1'b1;
      exp_q.push_back(model[0]);
      model = {img[i], model[L-1:1]};
    end
    @(negedge clk);
    svld_i = 1'b0;
  endtask

  task automatic do_update(input logic [L-1:0] exp_img);
    @(negedge clk);
    upd_i = 1'b1;
    #1 check(srdy_o == 1'b0, "R4 ready low on strobe", 64'(srdy_o), 0);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done falls at start", 64'(done_o), 0);
    check(act_cfg_o == exp_img, "R5 atomic load", 64'(act_cfg_o), 64'(exp_img));
    check(srdy_o == 1'b0, "R4 ready low busy1", 64'(srdy_o), 0);
    upd_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R6 done low second cycle", 64'(done_o), 0);
    check(srdy_o == 1'b0, "R4 ready low busy2", 64'(srdy_o), 0);
    @(negedge clk);
    check(done_o == 1'b1, "R6 done rises", 64'(done_o), 1);
    check(srdy_o == 1'b1, "R4 ready returns", 64'(srdy_o), 1);
  endtask

  initial begin
    dflt  = {NC{18'h10000}};
    model = dflt;
    img_a = {slot(3, 4, 1'b0, 1'b1), slot(5, 5, 1'b0, 1'b0)};
    img_b = {slot(4, 6, 1'b0, 1'b0), slot(9, 9, 1'b1, 1'b0)};
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(done_o == 1'b0, "R7 done cleared", 64'(done_o), 0);
    check(act_cfg_o == dflt, "R7 active default", 64'(act_cfg_o), 64'(dflt));
    check(div_ratio_o == {9'd1, 9'd1}, "R9 default ratio", 64'(div_ratio_o), 64'({9'd1, 9'd1}));
    check(sdata_o == 1'b0, "R7 shadow default bit0", 64'(sdata_o), 0);
    check(srdy_o == 1'b1, "R4 ready idle", 64'(srdy_o), 1);

    shift_in(img_a);
    check(act_cfg_o == dflt, "R5 active holds during shift", 64'(act_cfg_o), 64'(dflt));
    check(sdata_o == img_a[0], "R1 first bit at bit0", 64'(sdata_o), 64'(img_a[0]));
    sdata_i = ~img_a[0];
    repeat (4) @(negedge clk);
    check(sdata_o == img_a[0], "R2 hold without valid", 64'(sdata_o), 64'(img_a[0]));

    do_update(img_a);
    // R8 field layout and R9 ratio
    check(div_ratio_o[8:0] == 9'd10, "R9 even duty 5+5", 64'(div_ratio_o[8:0]), 10);
    check(div_ratio_o[17:9] == 9'd7, "R9 odd counter 3+4", 64'(div_ratio_o[17:9]), 7);
    check(act_cfg_o[35] == 1'b1, "R8 odd bit of counter 1", 64'(act_cfg_o[35]), 1);
    check(act_cfg_o[7:0] == 8'd5, "R8 high count slot 0", 64'(act_cfg_o[7:0]), 5);

    shift_in(img_b);  // reads back img_a (R3)
    check(act_cfg_o == img_a, "R5 holds while B shifts", 64'(act_cfg_o), 64'(img_a));
    // R4: strobe with valid offered; the bit must not be taken
    @(negedge clk);
    sdata_i = ~img_b[0];
    svld_i  = 1'b1;
    upd_i   = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    check(act_cfg_o == img_b, "R5 load B", 64'(act_cfg_o), 64'(img_b));
    @(negedge clk);
    @(negedge clk);
    svld_i = 1'b0;
    check(sdata_o == img_b[0], "R4 bit not taken while busy", 64'(sdata_o), 64'(img_b[0]));
    check(done_o == 1'b1, "R6 done after B", 64'(done_o), 1);
    check(div_ratio_o[8:0] == ratio_of(img_b[17:0]), "R9 bypass gives 1", 64'(div_ratio_o[8:0]), 64'(ratio_of(img_b[17:0])));
    check(div_ratio_o[17:9] == 9'd10, "R9 split duty 4+6", 64'(div_ratio_o[17:9]), 10);

    // R5 held strobe: one update only, done stays high
    shift_in(img_a);
    do_update(img_a);
    @(negedge clk);
    upd_i = 1'b0;
    @(negedge clk);
    upd_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R6 new update drops done", 64'(done_o), 0);
    repeat (6) @(negedge clk);
    check(done_o == 1'b1, "R5 held strobe single update", 64'(done_o), 1);
    check(srdy_o == 1'b0, "R4 ready low while strobe held", 64'(srdy_o), 0);
    upd_i = 1'b0;
    @(negedge clk);

    // R7 reset mid-run
    rst_n = 1'b0;
    #1;
    check(act_cfg_o == dflt, "R7 reset active", 64'(act_cfg_o), 64'(dflt));
    check(done_o == 1'b0, "R7 reset done", 64'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check(exp_q.size() == 0, "R3 all readback consumed", 64'(exp_q.size()), 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule